// File: doc/BRIEF.md
# Quadrature Up/Down Timer Channel

This block is one 16-bit timer channel whose count source is a pair of quadrature signals, phase A and phase B. Both phase pins and a capture pin are brought into the system clock domain. Every legal transition on either phase moves the counter one step. The order of the phases sets the step direction. If both phases change together, no step is taken.

Around the counter sit several parts. A general register serves either as a compare value or as a capture target. A clear option zeroes the counter on a compare or capture event. Three sticky status flags record match/capture, overflow and underflow. A readable direction bit shows the last count direction. An interrupt line is driven from the flags ANDed with their enable bits.

Software selects the quadrature mode code in the mode register and then raises the `run` input. Prescaler and clock-edge fields in the control register are stored and read back, but they do not change the count path.

Top module: `qtmr_channel`

## Requirements
- R1: After reset the counter reads 0x0000, the general register reads 0xFFFF, status reads 0x0008 (flags clear, direction bit 3 = 1) and `irq` is 0.
- R2: With mode field = 4'h4 and `run` = 1, every single-phase transition that follows the order (A,B) 00→10→11→01→00 (A leads) increments the counter by one.
- R3: Every single-phase transition in the reverse order (B leads) decrements the counter by one.
- R4: A sample in which both phases change at once produces no count.
- R5: With `run` = 0, or with a mode field other than 4'h4, phase transitions leave the counter unchanged.
- R6: Control bits [4:0] (prescaler and edge select) have no effect on quadrature counting.
- R7: An up step from 0xFFFF to 0x0000 sets the overflow flag, status bit 1.
- R8: A down step from 0x0000 to 0xFFFF sets the underflow flag, status bit 2.
- R9: Status bit 3 is 1 after an up step and 0 after a down step.
- R10: In compare mode (I/O control bit 3 = 0), the counter becoming equal to the general register sets status bit 0. If control bits [6:5] = 01, the next count step loads 0x0000 instead of stepping.
- R11: In capture mode (I/O control bit 3 = 1), a capture-pin edge that is enabled by I/O control bits [1:0] (bit 0 rising, bit 1 falling) copies the counter into the general register and sets status bit 0. An edge that is not enabled is ignored. If control bits [6:5] = 01, the counter is also zeroed.
- R12: A status flag is cleared only by writing 0 to it after it was read as 1. Writing 0 without such a read leaves the flag set.
- R13: `irq` is 1 one cycle after any flag is 1 together with its enable bit (interrupt enable bits [2:0] map to status bits [2:0]), and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Channel start; counting and capture only while 1 |
| pha | input | 1 | Phase A, asynchronous |
| phb | input | 1 | Phase B, asynchronous |
| cap_pin | input | 1 | Capture trigger, asynchronous |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register index: 0 mode, 1 control, 2 I/O control, 3 interrupt enable, 4 status, 5 counter, 6 general |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, registered on the edge that samples `rd_en` |
| irq | output | 1 | Registered interrupt request |

## Verification
A pin change made before clock edge k passes through two synchronizer stages. The counter, general register, flags and direction bit take the new value at edge k+2, and `irq` follows at edge k+3. Register read data is valid after the edge that samples the read strobe. The bench therefore waits three full cycles after every pin change before it reads back. It also waits two cycles after a write before it samples `irq`. All sampling happens on falling edges.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;
  localparam int ADDR_W = 3;
  localparam int MODE_W = 4;
  localparam int CTRL_W = 7;
  localparam int IOC_W  = 4;
  localparam int FLAG_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_MODE  = 3'd0,
    RA_CTRL  = 3'd1,
    RA_IOC   = 3'd2,
    RA_IEN   = 3'd3,
    RA_STAT  = 3'd4,
    RA_COUNT = 3'd5,
    RA_GREG  = 3'd6
  } reg_addr_e;

  localparam logic [MODE_W-1:0] MODE_QUAD = 4'h4;
  localparam logic [1:0]        CLR_GREG  = 2'b01;
  localparam int IOC_CAP_BIT = 3;
  localparam int FL_MC  = 0;
  localparam int FL_OVF = 1;
  localparam int FL_UNF = 2;
endpackage

// File: rtl/qtmr_sync_edge.sv
module qtmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic prev
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl  = sh_q[STAGES-1];
  assign prev = prev_q;
endmodule

// File: rtl/qtmr_quad_decode.sv
module qtmr_quad_decode (
  input  logic a,
  input  logic b,
  input  logic a_chg,
  input  logic b_chg,
  output logic up,
  output logic dn
);
  logic single, fwd;

  always_comb begin
    single = a_chg ^ b_chg;
    // A moved: forward when it now differs from B; B moved: forward when equal
    fwd    = a_chg ? (a != b) : (a == b);
    up     = single & fwd;
    dn     = single & ~fwd;
  end
endmodule

// File: rtl/qtmr_counter.sv
module qtmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_up,
  input  logic         step_dn,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic         clr_now,
  input  logic         clr_on_step,
  output logic [W-1:0] cnt,
  output logic         ovf_evt,
  output logic         unf_evt
);
  localparam logic [W-1:0] MAXV = '1;
  logic plain;

  always_comb begin
    plain   = ~ld_en & ~clr_now & ~clr_on_step;
    ovf_evt = plain & step_up & (cnt == MAXV);
    unf_evt = plain & step_dn & (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (ld_en)              cnt <= ld_val;
    else if (clr_now)            cnt <= '0;
    else if (step_up | step_dn) begin
      if (clr_on_step)           cnt <= '0;
      else if (step_up)          cnt <= cnt + W'(1);
      else                       cnt <= cnt - W'(1);
    end
  end
endmodule

// File: rtl/qtmr_channel.sv
module qtmr_channel
  import qtmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              pha,
  input  logic              phb,
  input  logic              cap_pin,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] pin_raw, pin_lvl, pin_prev, pin_chg;
  assign pin_raw = {cap_pin, phb, pha};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    qtmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (pin_raw[g]),
      .lvl  (pin_lvl[g]),
      .prev (pin_prev[g])
    );
  end
  assign pin_chg = pin_lvl ^ pin_prev;

  logic up_raw, dn_raw;
  qtmr_quad_decode u_dec (
    .a     (pin_lvl[0]),
    .b     (pin_lvl[1]),
    .a_chg (pin_chg[0]),
    .b_chg (pin_chg[1]),
    .up    (up_raw),
    .dn    (dn_raw)
  );

  logic [MODE_W-1:0] mode_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [IOC_W-1:0]  ioc_q;
  logic [FLAG_W-1:0] ien_q, flag_q, armed_q, flag_set;
  logic [CNT_W-1:0]  greg_q, cnt;
  logic              dir_q, match_q;

  logic cnt_en, step_up, step_dn, cap_mode, cap_rise, cap_fall, cap_evt;
  logic clr_sel, cmp_eq, clr_on_step, clr_now, cnt_ld, match_evt;
  logic ovf_evt, unf_evt, stat_rd, stat_wr;

  always_comb begin
    cnt_en      = run & (mode_q == MODE_QUAD);
    step_up     = cnt_en & up_raw;
    step_dn     = cnt_en & dn_raw;
    cap_mode    = ioc_q[IOC_CAP_BIT];
    cap_rise    = pin_lvl[2] & ~pin_prev[2];
    cap_fall    = ~pin_lvl[2] & pin_prev[2];
    cap_evt     = run & cap_mode & ((ioc_q[0] & cap_rise) | (ioc_q[1] & cap_fall));
    clr_sel     = (ctrl_q[6:5] == CLR_GREG);
    cmp_eq      = ~cap_mode & (cnt == greg_q);
    clr_on_step = clr_sel & cmp_eq;
    clr_now     = clr_sel & cap_evt;
    cnt_ld      = wr_en & (addr == RA_COUNT);
    match_evt   = cmp_eq & ~match_q;
    stat_rd     = rd_en & ~wr_en & (addr == RA_STAT);
    stat_wr     = wr_en & (addr == RA_STAT);
    flag_set    = '0;
    flag_set[FL_MC]  = match_evt | cap_evt;
    flag_set[FL_OVF] = ovf_evt;
    flag_set[FL_UNF] = unf_evt;
  end

  qtmr_counter #(.W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .step_up     (step_up),
    .step_dn     (step_dn),
    .ld_en       (cnt_ld),
    .ld_val      (wr_data),
    .clr_now     (clr_now),
    .clr_on_step (clr_on_step),
    .cnt         (cnt),
    .ovf_evt     (ovf_evt),
    .unf_evt     (unf_evt)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      ctrl_q <= '0;
      ioc_q  <= '0;
      ien_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        RA_MODE: mode_q <= wr_data[MODE_W-1:0];
        RA_CTRL: ctrl_q <= wr_data[CTRL_W-1:0];
        RA_IOC:  ioc_q  <= wr_data[IOC_W-1:0];
        RA_IEN:  ien_q  <= wr_data[FLAG_W-1:0];
        default: ;
      endcase
    end
  end

  // general register: write, else capture
  always_ff @(posedge clk) begin
    if (rst)                                 greg_q <= '1;
    else if (wr_en && (addr == RA_GREG))     greg_q <= wr_data;
    else if (cap_evt)                        greg_q <= cnt;
  end

  // flags, read-arming, direction, match edge
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= '0;
      armed_q <= '0;
      dir_q   <= 1'b1;
      match_q <= 1'b0;
    end else begin
      match_q <= cmp_eq;
      if (step_up)      dir_q <= 1'b1;
      else if (step_dn) dir_q <= 1'b0;
      if (stat_wr) begin
        flag_q  <= (flag_q & ~(armed_q & ~wr_data[FLAG_W-1:0])) | flag_set;
        armed_q <= '0;
      end else begin
        flag_q  <= flag_q | flag_set;
        if (stat_rd) armed_q <= armed_q | flag_q;
      end
    end
  end

  // registered read port and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= |(flag_q & ien_q);
      if (rd_en) begin
        case (addr)
          RA_MODE:  rd_data <= CNT_W'(mode_q);
          RA_CTRL:  rd_data <= CNT_W'(ctrl_q);
          RA_IOC:   rd_data <= CNT_W'(ioc_q);
          RA_IEN:   rd_data <= CNT_W'(ien_q);
          RA_STAT:  rd_data <= CNT_W'({dir_q, flag_q});
          RA_COUNT: rd_data <= cnt;
          RA_GREG:  rd_data <= greg_q;
          default:  rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/qtmr_channel_chk.sv
module qtmr_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             cnt_en,
  input logic             up_raw,
  input logic             dn_raw,
  input logic             a_chg,
  input logic             b_chg,
  input logic             cap_evt,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] greg,
  input logic             dir,
  input logic [2:0]       flags,
  input logic [2:0]       ien,
  input logic             irq
);
  logic quiet;
  assign quiet = !wr_en && !cap_evt;

  a_r2_up_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && up_raw && quiet && cnt != greg) |=> cnt == $past(cnt) + CNT_W'(1));
  a_r3_dn_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && dn_raw && quiet && cnt != greg) |=> cnt == $past(cnt) - CNT_W'(1));
  a_r4_no_double: assert property (@(posedge clk) disable iff (rst)
    (a_chg && b_chg && quiet) |=> $stable(cnt));
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && quiet) |=> $stable(cnt));
  a_r7_overflow: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && up_raw && quiet && cnt == '1 && cnt != greg) |=> flags[1]);
  a_r8_underflow: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && dn_raw && quiet && cnt == '0 && cnt != greg) |=> flags[2]);
  a_r9_dir_up: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && up_raw) |=> dir);
  a_r9_dir_dn: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && dn_raw) |=> !dir);
  a_r13_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (!(|(flags & ien))) |=> !irq);
endmodule

bind qtmr_channel qtmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .cnt_en  (cnt_en),
  .up_raw  (up_raw),
  .dn_raw  (dn_raw),
  .a_chg   (pin_chg[0]),
  .b_chg   (pin_chg[1]),
  .cap_evt (cap_evt),
  .cnt     (cnt),
  .greg    (greg_q),
  .dir     (dir_q),
  .flags   (flag_q),
  .ien     (ien_q),
  .irq     (irq)
);

// File: tb/tb_qtmr_channel.sv
module tb_qtmr_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        pha = 1'b0, phb = 1'b0, cap_pin = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int ph     = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  qtmr_channel dut (
    .clk(clk), .rst(rst), .run(run), .pha(pha), .phb(phb), .cap_pin(cap_pin),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); d = rd_data; rd_en = 1'b0;
  endtask

  // (A,B) order for forward rotation: 00, 10, 11, 01
  task automatic set_ph(input int idx);
    @(negedge clk);
    case (idx)
      0: begin pha = 1'b0; phb = 1'b0; end
      1: begin pha = 1'b1; phb = 1'b0; end
      2: begin pha = 1'b1; phb = 1'b1; end
      default: begin pha = 1'b0; phb = 1'b1; end
    endcase
    repeat (3) @(posedge clk);
  endtask

  task automatic fwd(input int n);
    for (int i = 0; i < n; i++) begin ph = (ph + 1) % 4; set_ph(ph); end
  endtask

  task automatic back(input int n);
    for (int i = 0; i < n; i++) begin ph = (ph + 3) % 4; set_ph(ph); end
  endtask

  task automatic set_cap(input logic v);
    @(negedge clk); cap_pin = v;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rreg(3'd5, v); check("R1 count", v, 16'h0000);
    rreg(3'd6, v); check("R1 greg", v, 16'hFFFF);
    rreg(3'd4, v); check("R1 status", v, 16'h0008);
    check("R1 irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_updown;
    logic [15:0] v;
    wreg(3'd0, 16'h0004); @(negedge clk); run = 1'b1;
    fwd(5);
    rreg(3'd5, v); check("R2 up count", v, 16'd5);
    rreg(3'd4, v); check("R9 dir up", v & 16'h8, 16'h8);
    back(3);
    rreg(3'd5, v); check("R3 down count", v, 16'd2);
    rreg(3'd4, v); check("R9 dir down", v & 16'h8, 16'h0);
  endtask

  task automatic t_illegal;
    logic [15:0] v;
    ph = 0; set_ph(0);              // from 11 straight to 00
    rreg(3'd5, v); check("R4 double change", v, 16'd2);
  endtask

  task automatic t_gate;
    logic [15:0] v;
    @(negedge clk); run = 1'b0;
    fwd(2);
    rreg(3'd5, v); check("R5 run low", v, 16'd2);
    @(negedge clk); run = 1'b1;
    wreg(3'd0, 16'h0000);
    fwd(1);
    rreg(3'd5, v); check("R5 other mode", v, 16'd2);
    wreg(3'd0, 16'h0004);
    wreg(3'd1, 16'h001F);
    fwd(2);
    rreg(3'd5, v); check("R6 presc bits ignored", v, 16'd4);
    wreg(3'd1, 16'h0000);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    wreg(3'd5, 16'hFFFE);
    fwd(2);
    rreg(3'd5, v); check("R7 wrap count", v, 16'h0000);
    rreg(3'd4, v); check("R7 overflow flag", v & 16'h2, 16'h2);
    back(1);
    rreg(3'd5, v); check("R8 wrap count", v, 16'hFFFF);
    rreg(3'd4, v); check("R8 underflow flag", v & 16'h4, 16'h4);
  endtask

  task automatic t_irq_clear;
    logic [15:0] v;
    repeat (2) @(negedge clk);
    check("R13 irq masked", {15'd0, irq}, 16'd0);
    wreg(3'd3, 16'h0002);
    repeat (2) @(negedge clk);
    check("R13 irq raised", {15'd0, irq}, 16'd1);
    wreg(3'd4, 16'h0007);           // disarms, clears nothing
    wreg(3'd4, 16'h0000);           // no read of 1 before: no effect
    rreg(3'd4, v); check("R12 unread write", v, 16'h0007);
    wreg(3'd4, 16'h0000);
    rreg(3'd4, v); check("R12 cleared", v, 16'h0000);
    repeat (2) @(negedge clk);
    check("R13 irq dropped", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_compare;
    logic [15:0] v;
    wreg(3'd5, 16'h0000);
    wreg(3'd6, 16'h0002);
    wreg(3'd1, 16'h0020);
    fwd(2);
    rreg(3'd5, v); check("R10 reach compare", v, 16'd2);
    rreg(3'd4, v); check("R10 match flag", v & 16'h1, 16'h1);
    fwd(1);
    rreg(3'd5, v); check("R10 clear on step", v, 16'd0);
    wreg(3'd4, 16'h0000);
    rreg(3'd4, v); check("R12 match cleared", v & 16'h7, 16'h0);
  endtask

  task automatic t_capture;
    logic [15:0] v;
    wreg(3'd1, 16'h0000);
    wreg(3'd2, 16'h0009);           // capture, rising only
    wreg(3'd5, 16'h1234);
    set_cap(1'b1);
    rreg(3'd6, v); check("R11 captured", v, 16'h1234);
    rreg(3'd4, v); check("R11 capture flag", v & 16'h1, 16'h1);
    wreg(3'd5, 16'h0100);
    set_cap(1'b0);
    rreg(3'd6, v); check("R11 falling ignored", v, 16'h1234);
    wreg(3'd2, 16'h000B);
    wreg(3'd1, 16'h0020);
    wreg(3'd5, 16'h0055);
    set_cap(1'b1);
    rreg(3'd6, v); check("R11 capture with clear", v, 16'h0055);
    rreg(3'd5, v); check("R11 counter zeroed", v, 16'h0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_updown;
    t_illegal;
    t_gate;
    t_wrap;
    t_irq_clear;
    t_compare;
    t_capture;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule